// File: doc/BRIEF.md
# Brown-out Step Dimmer

This block picks one of four output-current levels for an LED driver by counting short interruptions of the mains. The line-sense comparators report whether the sensed line is under the drop threshold and whether it is over the recovery threshold. An interruption counts only when the line stays low for longer than a blanking window. Each counted interruption stops switching and moves the level down one step. A counted interruption at the lowest level wraps back to full output.

An outage that lasts longer than a long-outage window puts the level back to full output. A supply reset does the same. An undervoltage lockout that starts before the blanking window ends records no step. After a lockout the driver resumes at the level it had. The block outputs the step index, a scaling word for the current reference, and the switching enable. Timing windows are counted in clock cycles and set by parameters.

Top module: `bsd_step_dimmer`

## Requirements
- R1: After power-up reset, step_o is 0, scale_o is full scale and run_o is 1.
- R2: scale_o equals round(FULL x P / 100), where FULL = 2^SCALE_W - 1 and P is 100, 70, 25 or 5 for step_o = 0, 1, 2 or 3. For 8 bits the codes are 255, 179, 64 and 13.
- R3: If line_low_i is high for at most BLANK_CYCLES consecutive sampled edges and then returns low, step_o is unchanged and run_o stays 1.
- R4: When line_low_i is high on BLANK_CYCLES+1 consecutive edges, step_o advances by one and run_o drops to 0, both on that last edge.
- R5: A qualified interruption while step_o is 3 sets step_o to 0.
- R6: After a qualified interruption, run_o stays 0 until line_ok_i is sampled high. On that edge run_o returns to 1 and step_o is kept.
- R7: If line_ok_i stays low for LONG_CYCLES+1 consecutive edges, counted from the first edge of the interruption, step_o returns to 0 on that edge and run_o stays 0.
- R8: While supply_rst_i is sampled high, step_o is forced to 0 and run_o is 0. The first edge that samples both supply_rst_i and uvlo_i low sets run_o back to 1.
- R9: uvlo_i sampled high while switching sets run_o to 0 and leaves step_o unchanged. An interruption in progress is dropped, so its blanking count starts again after the lockout ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| line_low_i | input | 1 | Line sense below the drop threshold |
| line_ok_i | input | 1 | Line sense above the recovery threshold |
| uvlo_i | input | 1 | Undervoltage lockout active |
| supply_rst_i | input | 1 | Supply below the state-reset level |
| step_o | output | 2 | Dimming step index, 0 = full output |
| scale_o | output | SCALE_W | Current-reference scaling word |
| run_o | output | 1 | Switching enable |

## Verification
The bench targets these corner cases:

- **Blanking boundary.** A low interval of exactly BLANK_CYCLES is followed by one a cycle longer. An off-by-one comparison would either dim on a glitch or need one cycle too many.
- **Wrap from the lowest level.** A design that saturates would stay dim here, and one that wraps wrongly would land on a middle level.
- **Long outage.** The window is measured from the first low edge, across both blanking and stop. A timer that restarts at the stop would reset late.
- **Lockout in the middle of blanking.** The lockout must drop the pending step and restart the count. A design that keeps the count would dim early.
- **Supply reset at a dimmed level.** The level must return to full at once.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int unsigned N_LEVELS = 4;
    localparam int unsigned STEP_W   = $clog2(N_LEVELS);

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BLANK = 2'd1,
        ST_STOP  = 2'd2,
        ST_LOCK  = 2'd3
    } bsd_state_e;

    typedef struct packed {
        bsd_state_e          state;
        logic [STEP_W-1:0]   step;
    } bsd_ctl_t;

    // percentage of nominal current for each dimming step
    function automatic int unsigned level_pct(input int unsigned idx);
        case (idx)
            0:       return 100;
            1:       return 70;
            2:       return 25;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/bsd_outage_timer.sv
module bsd_outage_timer #(
    parameter int unsigned LONG_CYCLES = 3000000,
    localparam int unsigned CW = $clog2(LONG_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          inc_i,
    input  logic          clear_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] SAT = CW'(LONG_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (start_i) begin
            cnt_d = CW'(1);
        end else if (inc_i && (cnt_q < SAT)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/bsd_level_map.sv
module bsd_level_map
    import bsd_pkg::*;
#(
    parameter int unsigned SCALE_W = 8
) (
    input  logic [STEP_W-1:0]  step_i,
    output logic [SCALE_W-1:0] scale_o
);

    localparam longint unsigned FULL = (64'd1 << SCALE_W) - 64'd1;

    logic [SCALE_W-1:0] code_tbl [N_LEVELS];

    for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
        localparam longint unsigned CODE =
            (FULL * longint'(level_pct(g)) + 64'd50) / 64'd100;
        assign code_tbl[g] = SCALE_W'(CODE);
    end

    assign scale_o = code_tbl[step_i];

endmodule

// File: rtl/bsd_step_dimmer.sv
module bsd_step_dimmer
    import bsd_pkg::*;
#(
    parameter int unsigned SCALE_W      = 8,
    parameter int unsigned BLANK_CYCLES = 25000,
    parameter int unsigned LONG_CYCLES  = 3000000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_low_i,
    input  logic               line_ok_i,
    input  logic               uvlo_i,
    input  logic               supply_rst_i,
    output logic [1:0]         step_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic               run_o
);

    localparam int unsigned CW = $clog2(LONG_CYCLES + 1);
    localparam logic [CW-1:0] BLANK_LIM = CW'(BLANK_CYCLES);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_CYCLES);

    bsd_ctl_t ctl_d, ctl_q;
    logic t_start, t_inc, t_clear;
    logic [CW-1:0] out_cnt;

    bsd_outage_timer #(.LONG_CYCLES(LONG_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (t_start),
        .inc_i   (t_inc),
        .clear_i (t_clear),
        .cnt_o   (out_cnt)
    );

    always_comb begin
        ctl_d   = ctl_q;
        t_start = 1'b0;
        t_inc   = 1'b0;
        t_clear = 1'b0;
        if (supply_rst_i) begin
            ctl_d.state = ST_LOCK;
            ctl_d.step  = '0;
            t_clear     = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_RUN: begin
                    if (uvlo_i) begin
                        ctl_d.state = ST_LOCK;
                        t_clear     = 1'b1;
                    end else if (line_low_i) begin
                        ctl_d.state = ST_BLANK;
                        t_start     = 1'b1;
                    end
                end
                ST_BLANK: begin
                    if (uvlo_i) begin
                        ctl_d.state = ST_LOCK;
                        t_clear     = 1'b1;
                    end else if (!line_low_i) begin
                        ctl_d.state = ST_RUN;
                        t_clear     = 1'b1;
                    end else if (out_cnt >= BLANK_LIM) begin
                        ctl_d.state = ST_STOP;
                        ctl_d.step  = ctl_q.step + STEP_W'(1);
                        t_inc       = 1'b1;
                    end else begin
                        t_inc = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (line_ok_i) begin
                        ctl_d.state = ST_RUN;
                        t_clear     = 1'b1;
                    end else if (out_cnt >= LONG_LIM) begin
                        ctl_d.step = '0;
                    end else begin
                        t_inc = 1'b1;
                    end
                end
                default: begin
                    t_clear = 1'b1;
                    if (!uvlo_i) ctl_d.state = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_RUN;
            ctl_q.step  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bsd_level_map #(.SCALE_W(SCALE_W)) map_i (
        .step_i  (ctl_q.step),
        .scale_o (scale_o)
    );

    assign step_o = ctl_q.step;
    assign run_o  = (ctl_q.state == ST_RUN) || (ctl_q.state == ST_BLANK);

endmodule

// File: rtl/bsd_step_dimmer_chk.sv
module bsd_step_dimmer_chk #(
    parameter int unsigned SCALE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_low_i,
    input logic               line_ok_i,
    input logic               uvlo_i,
    input logic               supply_rst_i,
    input logic [1:0]         step_o,
    input logic [SCALE_W-1:0] scale_o,
    input logic               run_o
);

    a_r2_full_code: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 2'd0) |-> (scale_o == {SCALE_W{1'b1}}));

    a_r4_step_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != $past(step_o)) |->
            ((step_o == 2'($past(step_o) + 2'd1)) || (step_o == 2'd0)));

    a_r6_stopped_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o != $past(step_o)) |-> !run_o);

    a_r8_supply_reset: assert property (@(posedge clk) disable iff (!rst_n)
        supply_rst_i |=> ((step_o == 2'd0) && !run_o));

    a_r9_uvlo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_i && !supply_rst_i && run_o) |=> (!run_o && $stable(step_o)));

    a_r3_line_good_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !line_low_i && !uvlo_i && !supply_rst_i) |=>
            (run_o && $stable(step_o)));

endmodule

bind bsd_step_dimmer bsd_step_dimmer_chk #(.SCALE_W(SCALE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_low_i   (line_low_i),
    .line_ok_i    (line_ok_i),
    .uvlo_i       (uvlo_i),
    .supply_rst_i (supply_rst_i),
    .step_o       (step_o),
    .scale_o      (scale_o),
    .run_o        (run_o)
);

// File: tb/bsd_step_dimmer_tb.sv
module bsd_step_dimmer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int B  = 20;
    localparam int L  = 200;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_low = 1'b0, line_ok = 1'b1, uvlo = 1'b0, srst = 1'b0;
    logic [1:0] step;
    logic [SW-1:0] scale;
    logic run;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_tag = "R2";
    bit model_on = 1'b0;

    int m_mode, m_step, m_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsd_step_dimmer #(.SCALE_W(SW), .BLANK_CYCLES(B), .LONG_CYCLES(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_low_i(line_low), .line_ok_i(line_ok),
        .uvlo_i(uvlo), .supply_rst_i(srst), .step_o(step), .scale_o(scale), .run_o(run)
    );

    function automatic int exp_scale(input int s);
        int pct;
        case (s)
            0: pct = 100; 1: pct = 70; 2: pct = 25; default: pct = 5;
        endcase
        return (((1 << SW) - 1) * pct + 50) / 100;
    endfunction

    // reference model: 0 switching, 1 blanking, 2 stopped, 3 locked out
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_step = 0; m_low = 0;
        end else if (srst) begin
            m_mode = 3; m_step = 0; m_low = 0;
        end else begin
            case (m_mode)
                0: if (uvlo) m_mode = 3;
                   else if (line_low) begin m_mode = 1; m_low = 1; end
                1: if (uvlo) begin m_mode = 3; m_low = 0; end
                   else if (!line_low) begin m_mode = 0; m_low = 0; end
                   else if (m_low >= B) begin
                       m_step = (m_step + 1) % 4; m_mode = 2; m_low = m_low + 1;
                   end else m_low = m_low + 1;
                2: if (line_ok) begin m_mode = 0; m_low = 0; end
                   else if (m_low >= L) m_step = 0;
                   else m_low = m_low + 1;
                default: if (!uvlo) m_mode = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && model_on) begin
            chk({cur_tag, " step"}, step, m_step);
            chk({cur_tag, " run"}, run, (m_mode <= 1) ? 1 : 0);
            chk("R2 scale", scale, exp_scale(step));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_line(input bit low, input bit ok);
        line_low = low; line_ok = ok;
    endtask

    task automatic qualify();
        set_line(1, 0); tick(B + 1);
        set_line(0, 1); tick(1);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick(1);
        cur_tag = "R1";
        chk("R1 step", step, 0); chk("R1 run", run, 1); chk("R1 scale", scale, 255);

        cur_tag = "R3";
        set_line(1, 0); tick(B);
        chk("R3 run at limit", run, 1);
        set_line(0, 1); tick(1);
        chk("R3 step", step, 0); chk("R3 run", run, 1);

        cur_tag = "R4";
        set_line(1, 0); tick(B);
        chk("R4 before edge", run, 1);
        tick(1);
        chk("R4 step", step, 1); chk("R4 run", run, 0); chk("R2 code70", scale, 179);

        cur_tag = "R6";
        tick(5); chk("R6 held", run, 0);
        set_line(0, 0); tick(3); chk("R6 mid band", run, 0);
        set_line(0, 1); tick(1);
        chk("R6 resume run", run, 1); chk("R6 keep step", step, 1);

        cur_tag = "R5";
        qualify(); chk("R2 code25", scale, 64);
        qualify(); chk("R2 code5", scale, 13); chk("R5 at 3", step, 3);
        qualify(); chk("R5 wrap", step, 0); chk("R5 run", run, 1);

        cur_tag = "R7";
        set_line(1, 0); tick(L);
        chk("R7 before", step, 1);
        tick(1);
        chk("R7 reset", step, 0); chk("R7 run", run, 0);
        set_line(0, 1); tick(1); chk("R7 resume", run, 1);

        cur_tag = "R9";
        set_line(1, 0); tick(10);
        uvlo = 1'b1; tick(1);
        chk("R9 run", run, 0); chk("R9 step", step, 0);
        uvlo = 1'b0; tick(1);
        chk("R9 resume", run, 1);
        tick(B);
        chk("R9 restart count", step, 0); chk("R9 still run", run, 1);
        set_line(0, 1); tick(1);

        cur_tag = "R8";
        qualify(); qualify();
        chk("R8 pre", step, 2);
        srst = 1'b1; tick(1);
        chk("R8 step", step, 0); chk("R8 run", run, 0);
        tick(2); chk("R8 hold", run, 0);
        srst = 1'b0; tick(1);
        chk("R8 release", run, 1);

        cur_tag = "R2";
        void'($urandom(32'd4242));
        for (int k = 0; k < 60; k++) begin
            set_line(0, 1); tick(1 + ($urandom % 40));
            set_line(1, 0);
            if (($urandom % 5) == 0) begin
                tick(1 + ($urandom % 15)); uvlo = 1'b1; tick(1 + ($urandom % 3)); uvlo = 1'b0;
            end
            tick(1 + ($urandom % 260));
            if (($urandom % 3) == 0) begin set_line(0, 0); tick(1 + ($urandom % 5)); end
            if (($urandom % 17) == 0) begin srst = 1'b1; tick(2); srst = 1'b0; end
        end
        set_line(0, 1); tick(2);
        finish_up();
    end

endmodule